// File: doc/BRIEF.md
# Two-Input Handshake Join Stage

This block joins two independent valid/ready producer streams, A and B, into one registered valid/ready output stream. An output beat is created only in a cycle when both producers offer data and the single output register can take a new beat. The two inputs are therefore always consumed together, or not at all. The output beat carries A's word, B's word, and their unsigned sum, which is one bit wider than an input word.

Every interface obeys the same back-pressure rule. A beat moves only in a cycle where valid and ready are both high. A producer that sees valid high and ready low must hold the same word and try again. Ready toward a producer may be high while that producer's valid is low. A consumer that wants ready only alongside valid can AND the two. The output register can take a new beat when the downstream consumer is ready or when the register is empty. A full register that the consumer does not take holds its beat unchanged. There is one clock and an asynchronous active-low reset.

Top module: `pair_join_stage`

## Requirements
- R1: Asserting reset, with or without a clock edge, forces `out_valid` low and `out_a`, `out_b` and `out_sum` to zero.
- R2: `a_ready` equals (`out_ready` OR NOT `out_valid`) AND `b_valid`, and `b_ready` equals (`out_ready` OR NOT `out_valid`) AND `a_valid`. Neither depends on that port's own valid.
- R3: In every cycle, a transfer on A (`a_valid` AND `a_ready`) occurs exactly when a transfer on B occurs, so a lone valid input is never consumed.
- R4: After each clock edge, `out_valid` is high if a pair was accepted on that edge, or if a beat was held that the consumer did not take. Otherwise it is low.
- R5: The output fields change only on a cycle that accepts a pair. While `out_valid` is high and `out_ready` is low, they stay stable.
- R6: The output beat has `out_a` equal to the accepted A word, `out_b` equal to the accepted B word, and `out_sum` equal to their unsigned sum in W+1 bits, with the carry in the top bit.
- R7: The Nth output beat carries the Nth word taken from A and the Nth word taken from B, with no beat lost or duplicated.
- R8: When both inputs stay valid and `out_ready` stays high, a pair is accepted on every cycle, giving one output beat per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Producer A offers a word |
| a_ready | output | 1 | Stage takes A's word this cycle if valid |
| a_data | input | W | Producer A word |
| b_valid | input | 1 | Producer B offers a word |
| b_ready | output | 1 | Stage takes B's word this cycle if valid |
| b_data | input | W | Producer B word |
| out_valid | output | 1 | Output register holds a beat |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_a | output | W | A word of the output beat |
| out_b | output | W | B word of the output beat |
| out_sum | output | W+1 | Sum of the two words |

## Verification
A wrong occupancy bit in the output register shows up within one cycle. It appears at the ports either as a ready offered while a held beat is refused, which makes a new pair overwrite that beat, or as a stale repeat of `out_valid`. A join-control fault that lets one side through alone does not show at the output at once. It appears a few beats later as A and B words that no longer pair by index. For that reason, every output beat is compared against the indexed record of what each side gave up. The sum field is checked exhaustively over all input-word pairs.

// File: rtl/pjs_pkg.sv
package pjs_pkg;
  // Width of the arithmetic result for a given input word width.
  function automatic int unsigned sum_width(input int unsigned w);
    return w + 1;
  endfunction

  // Total width of a packed output beat: two words plus the sum.
  function automatic int unsigned beat_width(input int unsigned w);
    return 2 * w + sum_width(w);
  endfunction
endpackage

// File: rtl/pjs_join_ctrl.sv
// Join control: a side is offered ready only when the stage can accept
// and the other side is also presenting data.
module pjs_join_ctrl (
  input  logic can_accept,
  input  logic a_valid,
  input  logic b_valid,
  output logic a_ready,
  output logic b_ready,
  output logic fire
);
  always_comb begin
    a_ready = can_accept & b_valid;
    b_ready = can_accept & a_valid;
    fire    = can_accept & a_valid & b_valid;
  end
endmodule

// File: rtl/pjs_beat_pack.sv
// Combinational formation of the output beat from the two input words.
module pjs_beat_pack #(
  parameter int unsigned W = 8,
  localparam int unsigned SW = pjs_pkg::sum_width(W),
  localparam int unsigned PW = pjs_pkg::beat_width(W)
) (
  input  logic [W-1:0]  word_a,
  input  logic [W-1:0]  word_b,
  output logic [PW-1:0] beat
);
  logic [SW-1:0] total;

  always_comb begin
    total = {1'b0, word_a} + {1'b0, word_b};
    beat  = {word_a, word_b, total};
  end
endmodule

// File: rtl/pjs_out_reg.sv
// Single registered handshake slot. Accepts when empty or draining.
module pjs_out_reg #(
  parameter int unsigned PW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_beat,
  input  logic          down_ready,
  output logic          can_accept,
  output logic          held_valid,
  output logic [PW-1:0] held_beat
);
  assign can_accept = down_ready | ~held_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_valid <= 1'b0;
    else        held_valid <= load | (held_valid & ~down_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_beat <= '0;
    else if (load) held_beat <= load_beat;
  end
endmodule

// File: rtl/pair_join_stage.sv
module pair_join_stage #(
  parameter int unsigned W = 8,
  localparam int unsigned SW = pjs_pkg::sum_width(W),
  localparam int unsigned PW = pjs_pkg::beat_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [W-1:0]  a_data,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [W-1:0]  b_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_a,
  output logic [W-1:0]  out_b,
  output logic [SW-1:0] out_sum
);
  logic          can_accept;
  logic          fire;
  logic [PW-1:0] next_beat;
  logic [PW-1:0] held_beat;

  pjs_join_ctrl u_ctrl (
    .can_accept (can_accept),
    .a_valid    (a_valid),
    .b_valid    (b_valid),
    .a_ready    (a_ready),
    .b_ready    (b_ready),
    .fire       (fire)
  );

  pjs_beat_pack #(.W(W)) u_pack (
    .word_a (a_data),
    .word_b (b_data),
    .beat   (next_beat)
  );

  pjs_out_reg #(.PW(PW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (fire),
    .load_beat  (next_beat),
    .down_ready (out_ready),
    .can_accept (can_accept),
    .held_valid (out_valid),
    .held_beat  (held_beat)
  );

  assign out_a   = held_beat[PW-1 -: W];
  assign out_b   = held_beat[SW +: W];
  assign out_sum = held_beat[SW-1:0];
endmodule

// File: rtl/pair_join_stage_chk.sv
module pair_join_stage_chk #(
  parameter int unsigned W = 8,
  localparam int unsigned SW = pjs_pkg::sum_width(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic          a_ready,
  input logic [W-1:0]  a_data,
  input logic          b_valid,
  input logic          b_ready,
  input logic [W-1:0]  b_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_a,
  input logic [W-1:0]  out_b,
  input logic [SW-1:0] out_sum
);
  logic take_a, take_b;
  assign take_a = a_valid & a_ready;
  assign take_b = b_valid & b_ready;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_a == '0 && out_b == '0 && out_sum == '0));

  assert_empty_offers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && b_valid) |-> a_ready);

  assert_paired_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_a == take_b);

  assert_take_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_a |=> out_valid);

  assert_drain_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !take_a) |=> !out_valid);

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_b)
                                   && $stable(out_sum)));

  assert_load_words_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_a |=> (out_a == $past(a_data) && out_b == $past(b_data)));

  assert_sum_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum == ({1'b0, out_a} + {1'b0, out_b})));
endmodule

bind pair_join_stage pair_join_stage_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .a_data    (a_data),
  .b_valid   (b_valid),
  .b_ready   (b_ready),
  .b_data    (b_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_a     (out_a),
  .out_b     (out_b),
  .out_sum   (out_sum)
);

// File: tb/pair_join_stage_tb.sv
`timescale 1ns/1ps
module pair_join_stage_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a_valid, b_valid, out_ready;
  logic         a_ready, b_ready, out_valid;
  logic [W-1:0] a_data, b_data, out_a, out_b;
  logic [W:0]   out_sum;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 0;

  logic [W-1:0] qa[$];
  logic [W-1:0] qb[$];

  always #4 clk = ~clk;

  pair_join_stage #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_b(out_b), .out_sum(out_sum)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One traffic phase. full_sweep: words are the index split into A and B
  // bytes so every pair of values appears; otherwise random words.
  task automatic run_phase(input int n, input int sa, input int sb, input int so,
                           input bit full_sweep);
    int  sent_a = 0, sent_b = 0, recv = 0;
    bit  took_a = 0, took_b = 0;
    bit  exp_ov = 0;
    bit  exp_ra, exp_rb;
    a_valid = 0; b_valid = 0;
    while (recv < n && !done) begin
      @(negedge clk);
      if (!a_valid || took_a) begin
        if (sent_a < n && ($urandom % 100) >= sa) begin
          a_valid = 1;
          a_data  = full_sweep ? W'(sent_a) : W'($urandom);
        end else a_valid = 0;
      end
      if (!b_valid || took_b) begin
        if (sent_b < n && ($urandom % 100) >= sb) begin
          b_valid = 1;
          b_data  = full_sweep ? W'(sent_b >> W) : W'($urandom);
        end else b_valid = 0;
      end
      out_ready = (($urandom % 100) >= so);
      #1;
      exp_ov = exp_ov;
      check(out_valid == exp_ov, "R4 out_valid", out_valid, exp_ov);
      exp_ra = (out_ready || !exp_ov) && b_valid;
      exp_rb = (out_ready || !exp_ov) && a_valid;
      check(a_ready == exp_ra, "R2 a_ready", a_ready, exp_ra);
      check(b_ready == exp_rb, "R2 b_ready", b_ready, exp_rb);
      took_a = a_valid && a_ready;
      took_b = b_valid && b_ready;
      check(took_a == took_b, "R3 paired take", took_a, took_b);
      if (full_sweep && sent_a < n)
        check(took_a, "R8 full rate", took_a, 1);
      if (out_valid) begin
        if (qa.size() == 0) check(0, "R7 spurious beat", out_a, 0);
        else begin
          check(out_a == qa[0], "R7 A pairing", out_a, qa[0]);
          check(out_b == qb[0], "R7 B pairing", out_b, qb[0]);
          check(out_sum == ({1'b0, qa[0]} + {1'b0, qb[0]}), "R6 sum",
                out_sum, {1'b0, qa[0]} + {1'b0, qb[0]});
          if (out_ready) begin
            void'(qa.pop_front()); void'(qb.pop_front()); recv++;
          end
        end
      end
      // R5: a held, untaken beat stays in the queue head and is rechecked next cycle
      if (took_a) begin qa.push_back(a_data); sent_a++; end
      if (took_b) begin qb.push_back(b_data); sent_b++; end
      exp_ov = took_a || (exp_ov && !out_ready);
    end
    @(negedge clk);
    a_valid = 0; b_valid = 0; out_ready = 1;
    @(negedge clk);
    check(qa.size() == 0 && qb.size() == 0, "R7 no loss", qa.size(), 0);
  endtask

  initial begin
    rst_n = 0; a_valid = 0; b_valid = 0; out_ready = 0;
    a_data = 0; b_data = 0;
    #20;
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    check(out_a == 0 && out_b == 0 && out_sum == 0, "R1 reset data",
          {out_a, out_b, out_sum}, 0);
    @(negedge clk) rst_n = 1;

    run_phase(1 << (2 * W), 0, 0, 0, 1);   // R6 R7 R8 exhaustive word pairs
    run_phase(3000, 40, 10, 30, 0);        // R2 R3 R4 R5 A-heavy stalls
    run_phase(3000, 10, 50, 50, 0);        // B-heavy stalls, strong back-pressure
    run_phase(2000, 60, 60, 70, 0);        // sparse traffic, mostly refused

    // R1: asynchronous reset between edges while a beat is held
    @(negedge clk);
    a_valid = 1; b_valid = 1; a_data = 8'hA5; b_data = 8'hC3; out_ready = 0;
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    #1;
    check(out_valid == 1 && out_a == 8'hA5, "R5 beat held before reset", out_a, 8'hA5);
    rst_n = 0;
    #1;
    check(out_valid == 0, "R1 async valid clear", out_valid, 0);
    check(out_a == 0 && out_b == 0 && out_sum == 0, "R1 async data clear",
          {out_a, out_b, out_sum}, 0);
    @(negedge clk) rst_n = 1;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 195000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule